// File: doc/BRIEF.md
# Accumulator Rotate and Flag-Op Unit

This is a purely combinational execution slice for an 8-bit accumulator datapath with a 16-bit pair adder. One operation code selects among four accumulator rotates (two circular, two through the carry flag), accumulator complement, carry set, carry complement, a 16-bit pair add, and a 16-bit doubling of one pair. The unit returns a new accumulator, a new 16-bit result and a new flag byte in the same cycle. Storage of registers and instruction sequencing stay with the surrounding core, which writes back whichever result the operation produced.

The flag byte uses fixed positions: bit 0 carry (C), bit 1 subtract (N), bit 2 parity/overflow (P/V), bit 3 copy bit, bit 4 half-carry (H), bit 5 copy bit, bit 6 zero (Z), bit 7 sign (S). Each operation keeps an exact subset of these bits and rewrites the rest.

Operation codes on `op_sel`: 1 circular left, 2 circular right, 3 left through carry, 4 right through carry, 5 complement, 6 set carry, 7 complement carry, 8 pair add, 9 pair double. All other codes are undefined.

Top module: `acc_flagop_unit`

## Requirements
- R1: For codes 1 to 4, `flg_out` bits 7, 6, 5, 3 and 2 equal the same bits of `flg_in`, and bits 4 and 1 are 0.
- R2: Code 1 shifts `acc_in` left by one with old bit 7 entering bit 0 and C; code 2 shifts right by one with old bit 0 entering bit 7 and C.
- R3: Code 3 shifts left with the old C entering bit 0 and old bit 7 going to C; code 4 shifts right with the old C entering bit 7 and old bit 0 going to C.
- R4: Code 5 gives `acc_out` as the bitwise inverse of `acc_in`, sets H and N, and keeps every other flag bit.
- R5: Code 6 sets C, clears H and N, and keeps every other flag bit with `acc_out` equal to `acc_in`.
- R6: Code 7 clears N, copies the old C into H, inverts C, and keeps every other flag bit with `acc_out` equal to `acc_in`.
- R7: Code 8 gives `wide_out` as the low 16 bits of `pair_a + pair_b`; C is bit 16 of the 17-bit sum, H is bit 12 of (sum XOR `pair_a` XOR `pair_b`), bits 7, 6 and 2 are kept and bits 5, 3 and 1 are 0.
- R8: Code 9 doubles `pair_a` (`pair_b` has no effect): `wide_out` is `pair_a` shifted left by one, C is old bit 15 of `pair_a`, H is bit 12 of the doubled value, flags otherwise as in R7.
- R9: For any code outside 1 to 9, `acc_out` equals `acc_in`, `flg_out` equals `flg_in` and `wide_out` equals `pair_a`.
- R10: Byte operations (codes 1 to 7) give `wide_out` equal to `pair_a`; pair operations (codes 8 and 9) give `acc_out` equal to `acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator |
| flg_in | input | 8 | Current flag byte |
| pair_a | input | 16 | Destination pair operand |
| pair_b | input | 16 | Source pair operand |
| acc_out | output | 8 | New accumulator |
| flg_out | output | 8 | New flag byte |
| wide_out | output | 16 | New 16-bit pair value |

## Verification
The bench builds the unit with its default widths, an 8-bit accumulator and a 16-bit pair, so the full accumulator space can be swept for every byte operation with the carry both clear and set, while the other flag bits carry varied patterns that expose any bit wrongly kept or dropped. At 16 bits the pair adder is covered with pseudo-random operands plus directed carry-out-of-bit-15 and carry-into-bit-12 cases, and the doubling code is driven with a junk second operand to show it is ignored. Every code from 10 to 15 and code 0 is swept for pass-through.

// File: rtl/acc_flagop_pkg.sv
package acc_flagop_pkg;

  localparam int FLAG_W = 8;

  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_H  = 4;

  // bits kept by rotates: S, Z, 5, 3, P/V
  localparam logic [FLAG_W-1:0] ROT_KEEP  = 8'hEC;
  // bits kept by pair add: S, Z, P/V
  localparam logic [FLAG_W-1:0] PAIR_KEEP = 8'hC4;

  typedef enum logic [3:0] {
    OP_RLC  = 4'd1,
    OP_RRC  = 4'd2,
    OP_RLT  = 4'd3,
    OP_RRT  = 4'd4,
    OP_CPL  = 4'd5,
    OP_SCF  = 4'd6,
    OP_CCF  = 4'd7,
    OP_PADD = 4'd8,
    OP_PDBL = 4'd9
  } op_code_e;

endpackage

// File: rtl/acc_rot_unit.sv
module acc_rot_unit
  import acc_flagop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        rot_kind,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [FLAG_W-1:0] flg_in,
  output logic [DATA_W-1:0] acc_out,
  output logic [FLAG_W-1:0] flg_out
);
  localparam int MSB = DATA_W - 1;

  logic carry_in;
  logic carry_out;

  assign carry_in = flg_in[FB_C];

  always_comb begin
    unique case (rot_kind)
      2'd0: begin
        acc_out   = {acc_in[MSB-1:0], acc_in[MSB]};
        carry_out = acc_in[MSB];
      end
      2'd1: begin
        acc_out   = {acc_in[0], acc_in[MSB:1]};
        carry_out = acc_in[0];
      end
      2'd2: begin
        acc_out   = {acc_in[MSB-1:0], carry_in};
        carry_out = acc_in[MSB];
      end
      default: begin
        acc_out   = {carry_in, acc_in[MSB:1]};
        carry_out = acc_in[0];
      end
    endcase
    flg_out = (flg_in & ROT_KEEP) | {{(FLAG_W-1){1'b0}}, carry_out};
  end

endmodule

// File: rtl/acc_flag_ops.sv
module acc_flag_ops
  import acc_flagop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        fop_kind,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [FLAG_W-1:0] flg_in,
  output logic [DATA_W-1:0] acc_out,
  output logic [FLAG_W-1:0] flg_out
);
  always_comb begin
    acc_out = acc_in;
    flg_out = flg_in;
    unique case (fop_kind)
      2'd0: begin
        acc_out       = ~acc_in;
        flg_out[FB_H] = 1'b1;
        flg_out[FB_N] = 1'b1;
      end
      2'd1: begin
        flg_out[FB_H] = 1'b0;
        flg_out[FB_N] = 1'b0;
        flg_out[FB_C] = 1'b1;
      end
      2'd2: begin
        flg_out[FB_N] = 1'b0;
        flg_out[FB_H] = flg_in[FB_C];
        flg_out[FB_C] = ~flg_in[FB_C];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_pair_adder.sv
module acc_pair_adder
  import acc_flagop_pkg::*;
#(
  parameter int WIDE_W = 16
) (
  input  logic [WIDE_W-1:0] dst_in,
  input  logic [WIDE_W-1:0] src_in,
  input  logic [FLAG_W-1:0] flg_in,
  output logic [WIDE_W-1:0] sum_out,
  output logic [FLAG_W-1:0] flg_out
);
  // half-carry is the carry into the top nibble
  localparam int HC_BIT = WIDE_W - 4;

  logic [WIDE_W:0]   sum_ext;
  logic [WIDE_W-1:0] carry_vec;

  always_comb begin
    sum_ext   = {1'b0, dst_in} + {1'b0, src_in};
    carry_vec = sum_ext[WIDE_W-1:0] ^ dst_in ^ src_in;
    sum_out   = sum_ext[WIDE_W-1:0];
    flg_out   = flg_in & PAIR_KEEP;
    flg_out[FB_C] = sum_ext[WIDE_W];
    flg_out[FB_H] = carry_vec[HC_BIT];
  end

endmodule

// File: rtl/acc_flagop_unit.sv
module acc_flagop_unit
  import acc_flagop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIDE_W = 16
) (
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [FLAG_W-1:0] flg_in,
  input  logic [WIDE_W-1:0] pair_a,
  input  logic [WIDE_W-1:0] pair_b,
  output logic [DATA_W-1:0] acc_out,
  output logic [FLAG_W-1:0] flg_out,
  output logic [WIDE_W-1:0] wide_out
);
  localparam int HC_BIT = WIDE_W - 4;

  op_code_e op;
  logic [1:0] rot_kind;
  logic [1:0] fop_kind;
  logic is_rot, is_fop, is_pair;

  logic [DATA_W-1:0] rot_acc, fop_acc;
  logic [FLAG_W-1:0] rot_flg, fop_flg, add_flg;
  logic [WIDE_W-1:0] add_src, add_sum;

  assign op = op_code_e'(op_sel);

  always_comb begin
    is_rot   = 1'b0;
    is_fop   = 1'b0;
    is_pair  = 1'b0;
    rot_kind = 2'd0;
    fop_kind = 2'd3;
    add_src  = pair_b;
    case (op)
      OP_RLC:  begin is_rot = 1'b1; rot_kind = 2'd0; end
      OP_RRC:  begin is_rot = 1'b1; rot_kind = 2'd1; end
      OP_RLT:  begin is_rot = 1'b1; rot_kind = 2'd2; end
      OP_RRT:  begin is_rot = 1'b1; rot_kind = 2'd3; end
      OP_CPL:  begin is_fop = 1'b1; fop_kind = 2'd0; end
      OP_SCF:  begin is_fop = 1'b1; fop_kind = 2'd1; end
      OP_CCF:  begin is_fop = 1'b1; fop_kind = 2'd2; end
      OP_PADD: begin is_pair = 1'b1; end
      OP_PDBL: begin is_pair = 1'b1; add_src = pair_a; end
      default: ;
    endcase
  end

  acc_rot_unit #(.DATA_W(DATA_W)) u_rot (
    .rot_kind (rot_kind),
    .acc_in   (acc_in),
    .flg_in   (flg_in),
    .acc_out  (rot_acc),
    .flg_out  (rot_flg)
  );

  acc_flag_ops #(.DATA_W(DATA_W)) u_fop (
    .fop_kind (fop_kind),
    .acc_in   (acc_in),
    .flg_in   (flg_in),
    .acc_out  (fop_acc),
    .flg_out  (fop_flg)
  );

  acc_pair_adder #(.WIDE_W(WIDE_W)) u_add (
    .dst_in  (pair_a),
    .src_in  (add_src),
    .flg_in  (flg_in),
    .sum_out (add_sum),
    .flg_out (add_flg)
  );

  always_comb begin
    acc_out  = acc_in;
    flg_out  = flg_in;
    wide_out = pair_a;
    if (is_rot) begin
      acc_out = rot_acc;
      flg_out = rot_flg;
    end else if (is_fop) begin
      acc_out = fop_acc;
      flg_out = fop_flg;
    end else if (is_pair) begin
      wide_out = add_sum;
      flg_out  = add_flg;
    end
  end

  // checks on the merged outputs against the inputs
  logic [WIDE_W:0] chk_sum;
  always_comb begin
    chk_sum = {1'b0, pair_a} + {1'b0, (op == OP_PDBL) ? pair_a : pair_b};
    if (is_rot) begin
      // R1
      rot_mask_chk: assert (((flg_out ^ flg_in) & ROT_KEEP) == '0 &&
                            flg_out[FB_H] == 1'b0 && flg_out[FB_N] == 1'b0);
    end
    if (op == OP_RLC) begin
      // R2
      rlc_wrap_chk: assert (acc_out[0] == flg_out[FB_C] && acc_out[0] == acc_in[DATA_W-1]);
    end
    if (op == OP_RRC) begin
      // R2
      rrc_wrap_chk: assert (acc_out[DATA_W-1] == flg_out[FB_C] && acc_out[DATA_W-1] == acc_in[0]);
    end
    if (op == OP_CCF) begin
      // R6
      ccf_swap_chk: assert (flg_out[FB_H] == flg_in[FB_C] && flg_out[FB_C] != flg_in[FB_C]);
    end
    if (is_pair) begin
      // R7
      pair_sum_chk: assert ({flg_out[FB_C], wide_out} == chk_sum &&
                            ((flg_out ^ flg_in) & PAIR_KEEP) == '0);
      // R10
      pair_acc_hold_chk: assert (acc_out == acc_in);
    end
    if (op == OP_PDBL) begin
      // R8
      dbl_half_chk: assert (flg_out[FB_H] == wide_out[HC_BIT] &&
                            flg_out[FB_C] == pair_a[WIDE_W-1]);
    end
    if (!is_rot && !is_fop && !is_pair) begin
      // R9
      undef_pass_chk: assert (acc_out == acc_in && flg_out == flg_in && wide_out == pair_a);
    end
  end

endmodule

// File: tb/test_acc_flagop_unit.sv
module test_acc_flagop_unit;

  logic clk;
  logic rst_n;
  logic [3:0]  op_sel;
  logic [7:0]  acc_in, flg_in, acc_out, flg_out;
  logic [15:0] pair_a, pair_b, wide_out;

  int total = 0;
  int bad   = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  acc_flagop_unit i_acc_flagop_unit (
    .op_sel(op_sel), .acc_in(acc_in), .flg_in(flg_in),
    .pair_a(pair_a), .pair_b(pair_b),
    .acc_out(acc_out), .flg_out(flg_out), .wide_out(wide_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] f,
                       input logic [15:0] pa, input logic [15:0] pb);
    @(negedge clk);
    op_sel = op; acc_in = a; flg_in = f; pair_a = pa; pair_b = pb;
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] ea, input logic [7:0] ef,
                       input logic [15:0] ew);
    total++;
    if (acc_out !== ea || flg_out !== ef || wide_out !== ew) begin
      bad++;
      $display("FAIL %s op=%0d a=%h f=%h: got acc=%h flg=%h wide=%h exp acc=%h flg=%h wide=%h",
               req, op_sel, acc_in, flg_in, acc_out, flg_out, wide_out, ea, ef, ew);
    end
  endtask

  // R9 idle state after reset: code 0 passes through
  task automatic t_reset;
    drive(4'd0, 8'h00, 8'h00, 16'h0000, 16'h0000);
    check("R9", 8'h00, 8'h00, 16'h0000);
  endtask

  // R1 R2 R3 R10: every accumulator value, both carries
  task automatic t_rotates;
    logic [7:0] ea, ef, f;
    logic c, co;
    for (int op = 1; op <= 4; op++) begin
      for (int cy = 0; cy < 2; cy++) begin
        for (int v = 0; v < 256; v++) begin
          f = 8'((v * 37) ^ 8'h5A);
          f[0] = cy[0];
          c = cy[0];
          case (op)
            1: begin ea = {v[6:0], v[7]}; co = v[7]; end
            2: begin ea = {v[0], v[7:1]}; co = v[0]; end
            3: begin ea = {v[6:0], c};    co = v[7]; end
            default: begin ea = {c, v[7:1]}; co = v[0]; end
          endcase
          ef = {f[7:5], 1'b0, f[3:2], 1'b0, co};
          drive(4'(op), 8'(v), f, 16'hBEEF, 16'h1234);
          check((op <= 2) ? "R2/R1/R10" : "R3/R1/R10", ea, ef, 16'hBEEF);
        end
      end
    end
  endtask

  // R4 R5 R6 R10
  task automatic t_flag_ops;
    logic [7:0] f, ef;
    for (int cy = 0; cy < 2; cy++) begin
      for (int v = 0; v < 256; v++) begin
        f = 8'((v * 91) ^ 8'hA3);
        f[0] = cy[0];
        ef = f | 8'h12;
        drive(4'd5, 8'(v), f, 16'h0F0F, 16'h0);
        check("R4", ~8'(v), ef, 16'h0F0F);
        ef = (f & ~8'h12) | 8'h01;
        drive(4'd6, 8'(v), f, 16'h0F0F, 16'h0);
        check("R5", 8'(v), ef, 16'h0F0F);
        ef = f & ~8'h13;
        ef[4] = cy[0];
        ef[0] = ~cy[0];
        drive(4'd7, 8'(v), f, 16'h0F0F, 16'h0);
        check("R6", 8'(v), ef, 16'h0F0F);
      end
    end
  endtask

  task automatic one_add(input logic [15:0] a, input logic [15:0] b, input logic [7:0] f);
    logic [16:0] s;
    logic [15:0] x;
    logic [7:0] ef;
    s = {1'b0, a} + {1'b0, b};
    x = s[15:0] ^ a ^ b;
    ef = (f & 8'hC4) | {3'b0, x[12], 3'b0, s[16]};
    drive(4'd8, 8'h3C, f, a, b);
    check("R7", 8'h3C, ef, s[15:0]);
  endtask

  // R7 R10
  task automatic t_pair_add;
    one_add(16'hFFFF, 16'h0001, 8'hFF);
    one_add(16'h0FFF, 16'h0001, 8'h00);
    one_add(16'h8000, 16'h8000, 8'h2A);
    one_add(16'h0000, 16'h0000, 8'hFF);
    for (int i = 0; i < 400; i++) begin
      lfsr = nxt(lfsr); lfsr = nxt(lfsr);
      one_add(lfsr[15:0], lfsr[31:16], lfsr[23:16] ^ lfsr[7:0]);
      lfsr = nxt(lfsr);
    end
  endtask

  // R8: doubling ignores pair_b
  task automatic t_double;
    logic [15:0] a, d;
    logic [7:0] f, ef;
    for (int i = 0; i < 300; i++) begin
      lfsr = nxt(lfsr); lfsr = nxt(lfsr);
      a = (i == 0) ? 16'h8800 : (i == 1) ? 16'h0800 : lfsr[15:0];
      f = lfsr[31:24];
      d = {a[14:0], 1'b0};
      ef = (f & 8'hC4) | {3'b0, d[12], 3'b0, a[15]};
      drive(4'd9, 8'h77, f, a, ~lfsr[31:16]);
      check("R8", 8'h77, ef, d);
    end
  endtask

  // R9: undefined codes
  task automatic t_undef;
    for (int op = 10; op < 17; op++) begin
      for (int k = 0; k < 8; k++) begin
        lfsr = nxt(lfsr);
        drive(4'(op), lfsr[7:0], lfsr[15:8], lfsr[31:16], lfsr[23:8]);
        check("R9", lfsr[7:0], lfsr[15:8], lfsr[31:16]);
      end
    end
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_sel = '0; acc_in = '0; flg_in = '0; pair_a = '0; pair_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset;
    t_rotates;
    t_flag_ops;
    t_pair_add;
    t_double;
    t_undef;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule